// File: doc/BRIEF.md
# Interrupt Controller with Port Change Detect

This block holds the interrupt-control state of a small microcontroller core. Four event sources feed it: an external pin whose active edge is selectable, a timer overflow pulse, a change detector watching four upper port pins, and a converter-done pulse. Each source owns a flag bit, which records that its event happened, and an enable bit, which lets that flag raise a request. A global enable gates the combined request that goes to the core.

When the core accepts an interrupt it pulses an acknowledge. The global enable then drops, so no nested request reaches the core until the handler's return strobe turns the global enable back on. The port-change detector keeps a latched copy of the port. Every port read refreshes that copy. The detector ORs together the per-pin differences between the latched and live values, counting only pins configured as inputs. The converter-done flag sits in its own status output and not among the main flags.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset every flag, every enable, the edge select, the global enable, the port latch and `irq_req` are 0.
- R2: With `ctl_rdata[4]` = 1, a rising edge on `ext_pin` sets `main_flags[0]`, and a falling edge does not. With it 0, only a falling edge sets the flag. The flag is set at the first clock edge that sees the new pin level.
- R3: A one-cycle `timer_ovf` pulse sets `main_flags[1]` at the next clock edge.
- R4: While any pin has a `port_dir` bit of 1 (input) and its live value differs from the latch, `main_flags[2]` is set at each clock edge. A pin whose `port_dir` bit is 0 (output) never sets the flag.
- R5: A `port_rd` strobe copies `port_pins` into `port_latch` at the next edge, which ends the mismatch. The port flag stays set until it is cleared.
- R6: A `flag_clr[i]` pulse clears flag i (0 external, 1 timer, 2 port, 3 converter). A set event in the same cycle wins, and with no clear a flag holds.
- R7: `irq_req` equals global enable AND the OR over i of (flag i AND enable i), with no added delay.
- R8: `irq_ack` clears the global enable at the next edge. `reti` sets it. The acknowledge wins over the return strobe and over a write, and the return strobe wins over a write.
- R9: A write with `ctl_we` loads the enables for sources 0..3 into bits 3:0, the edge select (1 = rising) into bit 4 and the global enable into bit 5. `ctl_rdata` returns them in the same positions.
- R10: A `cnv_done` pulse sets `cnv_flag`. That flag is held apart from `main_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin (already synchronous) |
| timer_ovf | input | 1 | Timer overflow pulse |
| cnv_done | input | 1 | Converter-done pulse |
| port_pins | input | 4 | Live upper port pin values |
| port_dir | input | 4 | Pin direction, 1 = input |
| port_rd | input | 1 | Port read strobe, refreshes the latch |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control write data {gie, edge, en[3:0]} |
| flag_clr | input | 4 | Per-flag clear pulses |
| irq_ack | input | 1 | Core accepts the interrupt |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Request to the core |
| ctl_rdata | output | 6 | Control register contents |
| main_flags | output | 3 | Flags {port, timer, external} |
| cnv_flag | output | 1 | Converter-done flag |
| port_latch | output | 4 | Latched port compare value |

## Verification
The bench sweeps all 16 flag patterns against all 32 enable and global-enable settings, and checks that the request follows the masked OR. A design that dropped the global gate, or that wired a wrong enable to a flag, shows up there. It drives the external pin through both edges under both edge settings, so an inverted select or a level-triggered detector gets caught. For each pin it tries both directions, which exposes a compare that ignores direction or a latch that never refreshes. Clear pulses that collide with set events catch a flag bank that gives the clear priority. Acknowledge and return strobes that collide with writes catch a wrong global-enable priority.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC  = 4;
  localparam int SRC_EXT  = 0;
  localparam int SRC_TMR  = 1;
  localparam int SRC_PORT = 2;
  localparam int SRC_CNV  = 3;
  localparam int CTL_W    = NUM_SRC + 2;
  localparam int CTL_EDGE = NUM_SRC;
  localparam int CTL_GIE  = NUM_SRC + 1;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic hit
);
  logic prev_q, prev_d;

  always_comb begin
    prev_d = pin;
    hit    = rise_sel ? (pin & ~prev_q) : (~pin & prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/irq_port_cmp.sv
module irq_port_cmp #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] dir_in,
  input  logic         rd,
  output logic [W-1:0] latch_q,
  output logic         change
);
  logic [W-1:0] latch_d;
  logic [W-1:0] diff;

  always_comb begin
    latch_d = rd ? pins : latch_q;
    diff    = (pins ^ latch_q) & dir_in;
    change  = |diff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  latch_q <= '0;
    else if (rd) latch_q <= latch_d;
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_ev,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic nxt;
    always_comb begin
      if (set_ev[i])      nxt = 1'b1;
      else if (clr_ev[i]) nxt = 1'b0;
      else                nxt = flag_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= nxt;
    end
  end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic              timer_ovf,
  input  logic              cnv_done,
  input  logic [PORT_W-1:0] port_pins,
  input  logic [PORT_W-1:0] port_dir,
  input  logic              port_rd,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic [NUM_SRC-1:0] flag_clr,
  input  logic              irq_ack,
  input  logic              reti,
  output logic              irq_req,
  output logic [CTL_W-1:0]  ctl_rdata,
  output logic [NUM_SRC-2:0] main_flags,
  output logic              cnv_flag,
  output logic [PORT_W-1:0] port_latch
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // control register
  logic [NUM_SRC-1:0] en_q, en_d;
  logic               edge_q, edge_d;
  logic               gie_q, gie_d;

  always_comb begin
    en_d   = ctl_we ? ctl_wdata[NUM_SRC-1:0] : en_q;
    edge_d = ctl_we ? ctl_wdata[CTL_EDGE]    : edge_q;
    if (irq_ack)     gie_d = 1'b0;
    else if (reti)   gie_d = 1'b1;
    else if (ctl_we) gie_d = ctl_wdata[CTL_GIE];
    else             gie_d = gie_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q   <= '0;
      edge_q <= 1'b0;
    end else if (ctl_we) begin
      en_q   <= en_d;
      edge_q <= edge_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) gie_q <= 1'b0;
    else             gie_q <= gie_d;
  end

  // event sources
  logic ext_hit, port_chg;
  logic [NUM_SRC-1:0] set_ev, flags;

  irq_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pin      (ext_pin),
    .rise_sel (edge_q),
    .hit      (ext_hit)
  );

  irq_port_cmp #(.W(PORT_W)) u_port (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pins    (port_pins),
    .dir_in  (port_dir),
    .rd      (port_rd),
    .latch_q (port_latch),
    .change  (port_chg)
  );

  always_comb begin
    set_ev           = '0;
    set_ev[SRC_EXT]  = ext_hit;
    set_ev[SRC_TMR]  = timer_ovf;
    set_ev[SRC_PORT] = port_chg;
    set_ev[SRC_CNV]  = cnv_done;
  end

  irq_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_ev (set_ev),
    .clr_ev (flag_clr),
    .flag_q (flags)
  );

  always_comb begin
    irq_req    = gie_q & |(flags & en_q);
    ctl_rdata  = {gie_q, edge_q, en_q};
    main_flags = flags[NUM_SRC-2:0];
    cnv_flag   = flags[SRC_CNV];
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       timer_ovf,
  input logic       cnv_done,
  input logic [3:0] port_pins,
  input logic       port_rd,
  input logic [3:0] flag_clr,
  input logic       irq_ack,
  input logic       reti,
  input logic       irq_req,
  input logic [5:0] ctl_rdata,
  input logic [2:0] main_flags,
  input logic       cnv_flag,
  input logic [3:0] port_latch
);
  assert_ack_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !ctl_rdata[5]);
  assert_reti_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !irq_ack) |=> ctl_rdata[5]);
  assert_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[5] |-> !irq_req);
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timer_ovf |=> main_flags[1]);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (main_flags[1] && !flag_clr[1]) |=> main_flags[1]);
  assert_cnv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_done |=> cnv_flag);
  assert_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd |=> (port_latch == $past(port_pins)));
endmodule

bind irq_ctrl_top irq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .timer_ovf  (timer_ovf),
  .cnv_done   (cnv_done),
  .port_pins  (port_pins),
  .port_rd    (port_rd),
  .flag_clr   (flag_clr),
  .irq_ack    (irq_ack),
  .reti       (reti),
  .irq_req    (irq_req),
  .ctl_rdata  (ctl_rdata),
  .main_flags (main_flags),
  .cnv_flag   (cnv_flag),
  .port_latch (port_latch)
);

// File: tb/irq_ctrl_top_tb.sv
module irq_ctrl_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_pin, timer_ovf, cnv_done, port_rd, ctl_we, irq_ack, reti;
  logic [3:0] port_pins, port_dir, flag_clr;
  logic [5:0] ctl_wdata;
  logic       irq_req, cnv_flag;
  logic [5:0] ctl_rdata;
  logic [2:0] main_flags;
  logic [3:0] port_latch;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_ctrl_top u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .timer_ovf(timer_ovf),
    .cnv_done(cnv_done), .port_pins(port_pins), .port_dir(port_dir),
    .port_rd(port_rd), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .flag_clr(flag_clr), .irq_ack(irq_ack), .reti(reti), .irq_req(irq_req),
    .ctl_rdata(ctl_rdata), .main_flags(main_flags), .cnv_flag(cnv_flag),
    .port_latch(port_latch)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] v);
    ctl_we = 1'b1; ctl_wdata = v; tick(); ctl_we = 1'b0;
  endtask

  task automatic clr_all();
    flag_clr = 4'hF; tick(); flag_clr = 4'h0;
  endtask

  initial begin
    rst_n = 1'b0; ext_pin = 0; timer_ovf = 0; cnv_done = 0; port_rd = 0;
    ctl_we = 0; irq_ack = 0; reti = 0; port_pins = 0; port_dir = 0;
    flag_clr = 0; ctl_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();
    // R1 reset state
    chk(ctl_rdata == 0, "R1 ctl", ctl_rdata, 0);
    chk(main_flags == 0, "R1 flags", main_flags, 0);
    chk(cnv_flag == 0, "R1 cnv", cnv_flag, 0);
    chk(irq_req == 0, "R1 req", irq_req, 0);
    chk(port_latch == 0, "R1 latch", port_latch, 0);

    // R9 control register write/read sweep
    for (int v = 0; v < 64; v++) begin
      wr(v[5:0]);
      chk(ctl_rdata == v[5:0], "R9 ctl", ctl_rdata, v);
    end

    // R7 request sweep over flag patterns and enable settings
    wr(6'b010000);
    port_dir = 4'hF; port_rd = 1; tick(); port_rd = 0;
    for (int fm = 0; fm < 16; fm++) begin
      clr_all();
      if (fm[0]) begin ext_pin = 1; tick(); ext_pin = 0; tick(); end
      if (fm[1]) begin timer_ovf = 1; tick(); timer_ovf = 0; end
      if (fm[2]) begin
        port_pins = port_pins ^ 4'h1; tick();
        port_rd = 1; tick(); port_rd = 0;
      end
      if (fm[3]) begin cnv_done = 1; tick(); cnv_done = 0; end
      chk(main_flags == fm[2:0], "R3 flags", main_flags, fm[2:0]);
      chk(cnv_flag == fm[3], "R10 cnv", cnv_flag, fm[3]);
      for (int c = 0; c < 32; c++) begin
        logic exp;
        wr({c[4], 1'b1, c[3:0]});
        exp = c[4] & (|(c[3:0] & fm[3:0]));
        chk(irq_req == exp, "R7 req", irq_req, exp);
      end
    end

    // R2 edge select
    wr(6'b010000); clr_all();
    ext_pin = 0; tick(); chk(main_flags[0] == 0, "R2 fall under rise", main_flags[0], 0);
    ext_pin = 1; tick(); chk(main_flags[0] == 1, "R2 rise", main_flags[0], 1);
    wr(6'b000000); clr_all();
    chk(main_flags[0] == 0, "R2 clr", main_flags[0], 0);
    ext_pin = 1; tick(); chk(main_flags[0] == 0, "R2 high under fall", main_flags[0], 0);
    ext_pin = 0; tick(); chk(main_flags[0] == 1, "R2 fall", main_flags[0], 1);
    ext_pin = 1; clr_all(); chk(main_flags[0] == 0, "R2 rise under fall", main_flags[0], 0);
    ext_pin = 0; tick(); clr_all();

    // R4/R5 per pin, per direction
    for (int i = 0; i < 4; i++) begin
      for (int d = 0; d < 2; d++) begin
        port_dir = 4'h0; port_rd = 1; tick(); port_rd = 0; clr_all();
        port_dir[i] = d[0];
        port_pins[i] = ~port_pins[i]; tick();
        chk(main_flags[2] == d[0], "R4 dir", main_flags[2], d);
        port_rd = 1; tick(); port_rd = 0;
        chk(port_latch == port_pins, "R5 latch", port_latch, port_pins);
        chk(main_flags[2] == d[0], "R5 flag held", main_flags[2], d);
        clr_all();
        chk(main_flags[2] == 0, "R5 cleared", main_flags[2], 0);
      end
    end

    // R6 set beats clear
    port_dir = 4'h0;
    timer_ovf = 1; flag_clr = 4'b0010; tick(); timer_ovf = 0; flag_clr = 0;
    chk(main_flags[1] == 1, "R6 set wins", main_flags[1], 1);
    flag_clr = 4'b0010; tick(); flag_clr = 0;
    chk(main_flags[1] == 0, "R6 clear", main_flags[1], 0);
    cnv_done = 1; flag_clr = 4'b1000; tick(); cnv_done = 0; flag_clr = 0;
    chk(cnv_flag == 1, "R6 cnv set wins", cnv_flag, 1);

    // R8 global enable sequencing
    clr_all();
    wr(6'b100010);
    timer_ovf = 1; tick(); timer_ovf = 0;
    chk(irq_req == 1, "R8 req", irq_req, 1);
    irq_ack = 1; tick(); irq_ack = 0;
    chk(ctl_rdata[5] == 0, "R8 ack", ctl_rdata[5], 0);
    chk(irq_req == 0, "R8 blocked", irq_req, 0);
    reti = 1; tick(); reti = 0;
    chk(ctl_rdata[5] == 1, "R8 reti", ctl_rdata[5], 1);
    chk(irq_req == 1, "R8 req back", irq_req, 1);
    irq_ack = 1; reti = 1; tick(); irq_ack = 0; reti = 0;
    chk(ctl_rdata[5] == 0, "R8 ack beats reti", ctl_rdata[5], 0);
    reti = 1; ctl_we = 1; ctl_wdata = 6'b000010; tick(); reti = 0; ctl_we = 0;
    chk(ctl_rdata[5] == 1, "R8 reti beats write", ctl_rdata[5], 1);
    irq_ack = 1; ctl_we = 1; ctl_wdata = 6'b100010; tick(); irq_ack = 0; ctl_we = 0;
    chk(ctl_rdata[5] == 0, "R8 ack beats write", ctl_rdata[5], 0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule